// File: doc/BRIEF.md
# Dynamic VID Reference Stepper

This block turns a 5-bit voltage-identification code into the digital setpoint that a switching regulator's reference DAC follows. The code bus is looked at only when a one-clock cycle-start strobe marks the beginning of a switching period. A code that differs from the one in force becomes a candidate. It is accepted only if the strobe that follows sees the same value again.

After a code is accepted, the setpoint does not jump. It slews toward the new level by one unit of 25 mV on every second strobe, in either direction, and it stops exactly on the level. If a new code is accepted during a slew, the level it is heading for is replaced. Stepping then carries on from the present setpoint without restarting the two-strobe rhythm.

All pins are plain level or pulse signals. The VID bus is a sampled level with no valid/ready handshake, so there is no back-pressure: the block never stalls the strobe, and a code that is present between strobes is simply not observed. The reset is synchronous. During reset the setpoint is loaded directly from whatever code is on the bus, with no slew.

Top module: `vid_ref_stepper`

## Requirements
- R1: While reset is high, the accepted code takes the value on the VID bus, the setpoint takes that code's level, and busy is low.
- R2: VID bus values that come and go between strobes leave the setpoint, busy and the accepted code unchanged.
- R3: A code that differs from the accepted code becomes the accepted code in the clock after the second consecutive strobe that samples it, and never earlier.
- R4: If the second strobe samples a different non-accepted code, that code becomes the new candidate and nothing is accepted. If it samples the accepted code again, the pending candidate is dropped.
- R5: The level of a code is 64 minus the code value, in 25 mV units, giving 64 (1.6 V) for code 0 and 33 for code 31.
- R6: After an acceptance strobe, the setpoint moves by exactly one unit on the second strobe and on every second strobe after that. A move from level 48 to level 56 therefore takes 8 steps over 16 strobes.
- R7: The setpoint steps up when below the level and down when above it, and it halts on the level with no overshoot.
- R8: Busy is high exactly when the setpoint differs from the level of the accepted code. It rises in the clock after an acceptance that leaves the setpoint off the level.
- R9: An acceptance during a slew replaces the level being approached, and the two-strobe step rhythm carries on unbroken.
- R10: The setpoint, busy and the accepted code change only in the clock that follows a strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cyc_start | input | 1 | One-clock pulse at the start of each switching period |
| vid | input | 5 | Voltage-identification code bus |
| ref_code | output | 7 | Reference setpoint in 25 mV units |
| busy | output | 1 | Setpoint is still slewing toward the accepted level |
| vid_acc | output | 5 | Code currently in force |

## Verification
On every cycle, the assertions check the following: outputs stay frozen in clocks not preceded by a strobe; a change of the accepted code needs two consecutive strobes that sample the same value; the setpoint never moves by more than one unit; and two moves are always at least two strobes apart. Other behaviour is shown only by the bench's scenarios. These are the reset-loaded level, the strobe on which the first step lands, the 16-strobe length of a 48-to-56 slew, and the exact stop in both directions. The same holds for the cancellation and restart of a candidate and for a retarget in the middle of a slew. Each of these is compared with a reference model that the bench computes under random code changes and random strobe spacing.

// File: rtl/vid_ref_pkg.sv
package vid_ref_pkg;

  // direction chosen for one setpoint move
  typedef enum logic [1:0] {
    DIR_HOLD = 2'd0,
    DIR_UP   = 2'd1,
    DIR_DOWN = 2'd2
  } step_dir_e;

  localparam int DEF_VID_W       = 5;
  localparam int DEF_REF_W       = 7;
  localparam int DEF_TOP_LEVEL   = 64;  // level of code 0 in 25 mV units
  localparam int DEF_STEP_CYCLES = 2;   // strobes between setpoint moves

endpackage

// File: rtl/vid_level_map.sv
module vid_level_map #(
  parameter int VID_W     = vid_ref_pkg::DEF_VID_W,
  parameter int REF_W     = vid_ref_pkg::DEF_REF_W,
  parameter int TOP_LEVEL = vid_ref_pkg::DEF_TOP_LEVEL
) (
  input  logic [VID_W-1:0] code,
  output logic [REF_W-1:0] level
);
  localparam logic [REF_W-1:0] TOPV = REF_W'(TOP_LEVEL);

  // descending table: each code unit lowers the level by one 25 mV unit
  always_comb level = TOPV - REF_W'(code);
endmodule

// File: rtl/vid_qualifier.sv
module vid_qualifier #(
  parameter int VID_W = vid_ref_pkg::DEF_VID_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             strobe,
  input  logic [VID_W-1:0] vid_in,
  output logic [VID_W-1:0] acc_q,
  output logic [VID_W-1:0] acc_nxt
);
  logic [VID_W-1:0] cand_q, cand_nxt;
  logic             cand_v_q, cand_v_nxt;

  always_comb begin
    acc_nxt    = acc_q;
    cand_nxt   = cand_q;
    cand_v_nxt = cand_v_q;
    if (strobe) begin
      if (cand_v_q && (vid_in == cand_q)) begin
        acc_nxt    = cand_q;     // held for a full period: accept
        cand_v_nxt = 1'b0;
      end else if (vid_in != acc_q) begin
        cand_nxt   = vid_in;     // new or replaced candidate
        cand_v_nxt = 1'b1;
      end else begin
        cand_v_nxt = 1'b0;       // bus went back to the code in force
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q    <= vid_in;
      cand_q   <= '0;
      cand_v_q <= 1'b0;
    end else begin
      acc_q    <= acc_nxt;
      cand_q   <= cand_nxt;
      cand_v_q <= cand_v_nxt;
    end
  end
endmodule

// File: rtl/step_cadence.sv
module step_cadence #(
  parameter int STEP_CYCLES = vid_ref_pkg::DEF_STEP_CYCLES
) (
  input  logic clk,
  input  logic rst,
  input  logic strobe,
  input  logic ramping,
  output logic step_due
);
  generate
    if (STEP_CYCLES <= 1) begin : g_every
      always_comb step_due = strobe && ramping;
    end else begin : g_count
      localparam int CW = $clog2(STEP_CYCLES);
      localparam logic [CW-1:0] LAST = CW'(STEP_CYCLES - 1);
      logic [CW-1:0] cnt_q;

      always_comb step_due = strobe && ramping && (cnt_q == LAST);

      always_ff @(posedge clk) begin
        if (rst) begin
          cnt_q <= '0;
        end else if (strobe) begin
          if (!ramping || (cnt_q == LAST)) cnt_q <= '0;
          else                             cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/ref_ramp.sv
module ref_ramp #(
  parameter int REF_W = vid_ref_pkg::DEF_REF_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_due,
  input  logic [REF_W-1:0] init_level,
  input  logic [REF_W-1:0] goal,
  output logic [REF_W-1:0] ref_q
);
  import vid_ref_pkg::*;

  step_dir_e dir;

  always_comb begin
    if (goal > ref_q)      dir = DIR_UP;
    else if (goal < ref_q) dir = DIR_DOWN;
    else                   dir = DIR_HOLD;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_q <= init_level;
    end else if (step_due) begin
      case (dir)
        DIR_UP:   ref_q <= ref_q + 1'b1;
        DIR_DOWN: ref_q <= ref_q - 1'b1;
        default:  ref_q <= ref_q;
      endcase
    end
  end
endmodule

// File: rtl/vid_ref_stepper.sv
module vid_ref_stepper #(
  parameter int VID_W       = vid_ref_pkg::DEF_VID_W,
  parameter int REF_W       = vid_ref_pkg::DEF_REF_W,
  parameter int TOP_LEVEL   = vid_ref_pkg::DEF_TOP_LEVEL,
  parameter int STEP_CYCLES = vid_ref_pkg::DEF_STEP_CYCLES
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cyc_start,
  input  logic [VID_W-1:0] vid,
  output logic [REF_W-1:0] ref_code,
  output logic             busy,
  output logic [VID_W-1:0] vid_acc
);
  logic [VID_W-1:0] acc_q, acc_nxt;
  logic [REF_W-1:0] lvl_now, lvl_next, lvl_reset, ref_q;
  logic             ramping, step_due;

  vid_qualifier #(.VID_W(VID_W)) u_qual (
    .clk(clk), .rst(rst), .strobe(cyc_start), .vid_in(vid),
    .acc_q(acc_q), .acc_nxt(acc_nxt)
  );

  vid_level_map #(.VID_W(VID_W), .REF_W(REF_W), .TOP_LEVEL(TOP_LEVEL))
    u_map_now   (.code(acc_q),   .level(lvl_now));
  vid_level_map #(.VID_W(VID_W), .REF_W(REF_W), .TOP_LEVEL(TOP_LEVEL))
    u_map_next  (.code(acc_nxt), .level(lvl_next));
  vid_level_map #(.VID_W(VID_W), .REF_W(REF_W), .TOP_LEVEL(TOP_LEVEL))
    u_map_reset (.code(vid),     .level(lvl_reset));

  // slewing is judged against the level in force before this strobe
  always_comb ramping = (ref_q != lvl_now);

  step_cadence #(.STEP_CYCLES(STEP_CYCLES)) u_cad (
    .clk(clk), .rst(rst), .strobe(cyc_start), .ramping(ramping),
    .step_due(step_due)
  );

  // a move heads for the level that this very strobe may have accepted
  ref_ramp #(.REF_W(REF_W)) u_ramp (
    .clk(clk), .rst(rst), .step_due(step_due),
    .init_level(lvl_reset), .goal(lvl_next), .ref_q(ref_q)
  );

  assign ref_code = ref_q;
  assign busy     = ramping;
  assign vid_acc  = acc_q;
endmodule

// File: rtl/vid_ref_stepper_chk.sv
module vid_ref_stepper_chk #(
  parameter int VID_W       = 5,
  parameter int REF_W       = 7,
  parameter int STEP_CYCLES = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             cyc_start,
  input logic [VID_W-1:0] vid,
  input logic [REF_W-1:0] ref_code,
  input logic             busy,
  input logic [VID_W-1:0] vid_acc
);
  localparam int GW = $clog2(STEP_CYCLES + 1) + 1;
  localparam logic [GW-1:0]    GSAT = GW'(STEP_CYCLES);
  localparam logic [REF_W-1:0] ONE  = REF_W'(1);

  logic [VID_W-1:0] last_vid;
  logic             last_ok;
  logic [REF_W-1:0] prev_ref;
  logic [GW-1:0]    gap;

  always_ff @(posedge clk) begin
    prev_ref <= ref_code;
    if (rst) begin
      last_vid <= '0;
      last_ok  <= 1'b0;
      gap      <= GSAT;
    end else begin
      if (cyc_start) begin
        last_vid <= vid;
        last_ok  <= 1'b1;
      end
      if (ref_code != prev_ref) gap <= cyc_start ? GW'(1) : '0;
      else if (cyc_start && gap < GSAT) gap <= gap + 1'b1;
    end
  end

  // R10: no strobe, no output movement
  p_hold_between_r10: assert property (@(posedge clk) disable iff (rst)
    !cyc_start |=> ($stable(ref_code) && $stable(busy) && $stable(vid_acc)));

  // R3: acceptance needs two consecutive strobes with the same sample
  p_accept_repeat_r3: assert property (@(posedge clk) disable iff (rst)
    (cyc_start && !(last_ok && (vid == last_vid))) |=> $stable(vid_acc));

  // R6: a move is a single unit
  p_unit_step_r6: assert property (@(posedge clk) disable iff (rst)
    cyc_start |=> ((ref_code == $past(ref_code)) ||
                   (ref_code == $past(ref_code) + ONE) ||
                   (ref_code == $past(ref_code) - ONE)));

  // R6: moves are at least the cadence apart
  p_step_spacing_r6: assert property (@(posedge clk) disable iff (rst)
    (ref_code != prev_ref) |-> (gap >= GSAT));
endmodule

bind vid_ref_stepper vid_ref_stepper_chk #(
  .VID_W(VID_W), .REF_W(REF_W), .STEP_CYCLES(STEP_CYCLES)
) u_chk (
  .clk(clk), .rst(rst), .cyc_start(cyc_start), .vid(vid),
  .ref_code(ref_code), .busy(busy), .vid_acc(vid_acc)
);

// File: tb/vid_ref_stepper_test.sv
module vid_ref_stepper_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cyc_start = 1'b0;
  logic [4:0] vid = 5'd16;
  logic [6:0] ref_code;
  logic       busy;
  logic [4:0] vid_acc;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // bench reference state
  int m_acc, m_cand, m_ref, m_cnt;
  bit m_cv;

  vid_ref_stepper uut (
    .clk(clk), .rst(rst), .cyc_start(cyc_start), .vid(vid),
    .ref_code(ref_code), .busy(busy), .vid_acc(vid_acc)
  );

  always #2 clk = ~clk;  // 250 MHz

  function automatic int lvl(int code);
    return 64 - code;  // R5
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_strobe(int v);
    bit was_ramping;
    int goal;
    was_ramping = (m_ref != lvl(m_acc));
    if (m_cv && v == m_cand) begin m_acc = v; m_cv = 1'b0; end
    else if (v != m_acc) begin m_cand = v; m_cv = 1'b1; end
    else m_cv = 1'b0;
    goal = lvl(m_acc);
    if (!was_ramping) m_cnt = 0;
    else if (m_cnt == 1) begin
      m_cnt = 0;
      if (m_ref < goal) m_ref++;
      else if (m_ref > goal) m_ref--;
    end else m_cnt++;
  endtask

  task automatic compare_all(string tag);
    chk({tag, " ref R6/R7"}, ref_code, m_ref);
    chk({tag, " busy R8"}, busy, (m_ref != lvl(m_acc)) ? 1 : 0);
    chk({tag, " acc R3/R4"}, vid_acc, m_acc);
  endtask

  // one clock, starting and ending at a falling edge
  task automatic tick(bit s, logic [4:0] v, string tag);
    vid = v;
    cyc_start = s;
    if (s) model_strobe(v);
    @(posedge clk);
    @(negedge clk);
    cyc_start = 1'b0;
    compare_all(tag);
  endtask

  task automatic do_reset(logic [4:0] v);
    rst = 1'b1; vid = v; cyc_start = 1'b0;
    repeat (3) @(negedge clk);
    m_acc = v; m_ref = lvl(v); m_cv = 1'b0; m_cnt = 0;
    rst = 1'b0;
    chk("R1 reset ref", ref_code, lvl(v));
    chk("R1 reset busy", busy, 0);
    chk("R1 reset acc", vid_acc, v);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    int n;
    logic [4:0] cur;
    void'($urandom(32'd20240611));
    @(negedge clk);

    // R1, R5: reset at code 16 gives level 48
    do_reset(5'd16);
    chk("R5 level of 16", ref_code, 48);

    // R2: glitches between strobes are invisible
    tick(0, 5'd8, "R2");
    tick(0, 5'd3, "R2");
    tick(0, 5'd16, "R2");
    chk("R2 ref held", ref_code, 48);

    // R3, R6: 48 -> 56 with code 8
    tick(1, 5'd8, "R3 first");
    chk("R3 not yet accepted", vid_acc, 16);
    tick(0, 5'd8, "R3");
    tick(1, 5'd8, "R3 second");
    chk("R3 accepted", vid_acc, 8);
    chk("R8 busy after accept", busy, 1);
    chk("R6 no jump", ref_code, 48);
    n = 0;
    while (busy && n < 40) begin
      tick(0, 5'd8, "R6");
      tick(1, 5'd8, "R6");
      n++;
      if (n == 1) chk("R6 first strobe holds", ref_code, 48);
      if (n == 2) chk("R6 first step", ref_code, 49);
    end
    chk("R6 strobes for 8 steps", n, 16);
    chk("R7 stop up", ref_code, 56);

    // R7: down ramp back to 48
    n = 0;
    tick(1, 5'd16, "R7");
    tick(1, 5'd16, "R7");
    while (busy && n < 40) begin tick(1, 5'd16, "R7"); n++; end
    chk("R7 stop down", ref_code, 48);
    chk("R7 idle after down", busy, 0);

    // R4: unstable code restarts, revert cancels
    tick(1, 5'd3, "R4");
    tick(1, 5'd4, "R4");
    chk("R4 restart no accept", vid_acc, 16);
    tick(1, 5'd16, "R4");
    tick(1, 5'd4, "R4");
    chk("R4 cancel no accept", vid_acc, 16);
    tick(1, 5'd5, "R4");
    tick(1, 5'd16, "R4");
    chk("R4 unstable ref", ref_code, 48);

    // R9: retarget mid ramp toward 52 (code 12)
    tick(1, 5'd8, "R9");
    tick(1, 5'd8, "R9");
    repeat (5) tick(1, 5'd8, "R9");
    tick(1, 5'd12, "R9");
    tick(1, 5'd12, "R9");
    chk("R9 new target", vid_acc, 12);
    n = 0;
    while (busy && n < 40) begin tick(1, 5'd12, "R9"); n++; end
    chk("R9 settle", ref_code, 52);

    // R1, R5: boundary codes via reset
    do_reset(5'd31);
    chk("R5 level of 31", ref_code, 33);
    tick(1, 5'd0, "R5");
    tick(1, 5'd0, "R5");
    n = 0;
    while (busy && n < 80) begin tick(1, 5'd0, "R5"); n++; end
    chk("R5 level of 0", ref_code, 64);
    chk("R6 31 steps", n, 62);

    // random stimulus against the reference model
    cur = vid_acc;
    for (int i = 0; i < 3000; i++) begin
      int gap;
      if ($urandom_range(3, 0) == 0) cur = 5'($urandom_range(31, 0));
      gap = $urandom_range(3, 0);
      for (int g = 0; g < gap; g++)
        tick(0, ($urandom_range(1, 0) == 1) ? 5'($urandom_range(31, 0)) : cur, "R10 rnd");
      tick(1, cur, "R9 rnd");
      if (i == 1500) begin
        do_reset(5'($urandom_range(31, 0)));
        cur = vid_acc;
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule